// File: doc/BRIEF.md
# I2C Target Interface with Address Match

This block is the target (slave) side of a two-wire I2C bus. It oversamples the open-drain clock and data lines with the system clock and finds START, repeated START and STOP conditions. It shifts in the first byte after a START, compares its upper seven bits with a programmable own address, and can also accept the all-zero general call. The R/W bit then selects receive or transmit operation.

The local host sees each byte at a handoff. At every handoff the block raises a flag and, while the host needs time, holds the clock line low. The host reads the received byte or supplies the next byte to send, then pulses a clear input to release the bus. Acknowledge generation is gated by an enable input. A separate enable controls general-call acceptance. A three-bit status code tells the host which event caused the latest handoff.

The pins `scl_pull` and `sda_pull` mean "drive this line low". The outside pad logic turns them into open-drain drivers. The inputs `scl_i` and `sda_i` are the wired-AND line levels.

Top module: `i2cs_core`

## Requirements
- R1: A START (SDA falling while SCL is high) starts address reception. Every received byte is sampled on SCL rising edges, most significant bit first.
- R2: The address byte carries the target address in bits 7..1 and R/W in bit 0 (0 = controller writes, 1 = controller reads). When bits 7..1 equal `own_addr` and `ack_en` is 1, the block pulls SDA low through the ninth clock. SDA changes only while SCL is low.
- R3: Address 0x00 with R/W = 0 is accepted, acknowledged and reported with status 3 only when `gcall_en` is 1. Otherwise it gets no ACK.
- R4: While `ack_en` is 0, the block never acknowledges an address or a data byte, never stretches, and behaves as if absent.
- R5: In receive mode with `ack_en` set, every data byte is acknowledged, copied to `rx_byte`, and reported with status 4. An accepted write address is copied to `rx_byte` and reported with status 1.
- R6: A target that is not addressed pulls neither line and ignores every byte and START until the next STOP.
- R7: For a received byte that will be acknowledged, the falling edge after the eighth bit sets `hold_flag`, holds SCL low and drives the ACK. SCL stays held until `hold_clr` is pulsed. `scl_pull` is never 1 while `hold_flag` is 0.
- R8: After an acknowledged read address, the falling edge of the ninth clock sets `hold_flag`, holds SCL low and reports status 2. When `hold_clr` is pulsed, `tx_byte` is driven out on SDA, most significant bit first.
- R9: In transmit mode, an ACK from the controller on the ninth clock gives status 5 and a new stretched handoff. A NACK gives status 6 and sets `hold_flag` without stretching. Both lines are then released until STOP.
- R10: A STOP (SDA rising while SCL is high) releases both lines, returns to idle and sets status 7.
- R11: A repeated START (a START with no STOP before it) restarts address reception, so a write followed by a read can share one bus ownership.
- R12: After reset, status is 0, `hold_flag` is 0 and neither line is pulled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the bus clock line |
| sda_i | input | 1 | Sensed level of the bus data line |
| scl_pull | output | 1 | 1 = pull SCL low (clock stretch) |
| sda_pull | output | 1 | 1 = pull SDA low (ACK or a 0 data bit) |
| own_addr | input | ADDR_W | Own 7-bit target address |
| ack_en | input | 1 | Allows acknowledge generation |
| gcall_en | input | 1 | Allows the general call to be accepted |
| tx_byte | input | ADDR_W+1 | Byte to send, taken when `hold_clr` ends a transmit handoff |
| rx_byte | output | ADDR_W+1 | Last acknowledged received byte |
| hold_flag | output | 1 | A byte handoff is waiting for the host |
| hold_clr | input | 1 | One-cycle pulse that clears `hold_flag` and releases SCL |
| status | output | 3 | 0 idle, 1 write address, 2 read address, 3 general call, 4 data received, 5 sent and ACKed, 6 sent and NACKed, 7 STOP |

## Verification
A wrong bit count or phase shows up at the ports within one SCL period: the ACK lands on the wrong clock, or the stretch and `hold_flag` appear at the wrong edge. A wrong match decision shows up at the ninth clock of the address byte, as an ACK where none is due or a missing one. A phase that fails to return to ignore or idle is exposed by the next byte or STOP: the target pulls a line it should leave alone, or shows a status other than the expected code. The bench acts as controller and host, and it also watches every clock for SDA moving while SCL is high.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ADDR_WR = 3'd1,
    ST_ADDR_RD = 3'd2,
    ST_GCALL   = 3'd3,
    ST_RX_ACK  = 3'd4,
    ST_TX_ACK  = 3'd5,
    ST_TX_NACK = 3'd6,
    ST_STOP    = 3'd7
  } stat_e;

  typedef enum logic [2:0] {
    P_IDLE,
    P_RECV,
    P_HOLD,
    P_ACK,
    P_TXWAIT,
    P_SEND,
    P_MACK,
    P_IGNORE
  } phase_e;

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] scl_q, sda_q;
  logic             scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[DEPTH-2:0], scl_i};
      sda_q <= {sda_q[DEPTH-2:0], sda_i};
    end
  end

  always_comb begin
    scl_s     = scl_q[STAGES-1];
    sda_s     = sda_q[STAGES-1];
    scl_p     = scl_q[STAGES];
    sda_p     = sda_q[STAGES];
    scl_rise  = scl_s & ~scl_p;
    scl_fall  = ~scl_s & scl_p;
    start_det = scl_s & scl_p & ~sda_s & sda_p;
    stop_det  = scl_s & scl_p & sda_s & ~sda_p;
  end

endmodule

// File: rtl/i2cs_addr_cmp.sv
module i2cs_addr_cmp #(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W:0]   byte_in,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gcall_en,
  output logic              hit,
  output logic              gcall,
  output logic              rd
);
  logic [ADDR_W-1:0] addr;
  logic              own_hit;

  always_comb begin
    addr    = byte_in[ADDR_W:1];
    rd      = byte_in[0];
    own_hit = (addr == own_addr);
    gcall   = (addr == '0) && gcall_en && !rd;
    hit     = own_hit || gcall;
  end

endmodule

// File: rtl/i2cs_core.sv
module i2cs_core
  import i2cs_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull,
  output logic              sda_pull,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_en,
  input  logic              gcall_en,
  input  logic [ADDR_W:0]   tx_byte,
  output logic [ADDR_W:0]   rx_byte,
  output logic              hold_flag,
  input  logic              hold_clr,
  output logic [2:0]        status
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i = rst_q[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_i), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  phase_e            ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d, rx_q, rx_d;
  logic              isaddr_q, isaddr_d, rd_q, rd_d;
  logic              hold_q, hold_d, sdap_q, sdap_d, sclp_q, sclp_d;
  stat_e             st_q, st_d;
  logic              hit, gcall, rd_bit;

  i2cs_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .byte_in(sh_q), .own_addr(own_addr), .gcall_en(gcall_en),
    .hit(hit), .gcall(gcall), .rd(rd_bit)
  );

  always_comb begin
    ph_d = ph_q; cnt_d = cnt_q; sh_d = sh_q; rx_d = rx_q;
    isaddr_d = isaddr_q; rd_d = rd_q; hold_d = hold_q;
    sdap_d = sdap_q; sclp_d = sclp_q; st_d = st_q;
    if (hold_clr) hold_d = 1'b0;
    if (stop_det) begin
      ph_d = P_IDLE; sdap_d = 1'b0; sclp_d = 1'b0; st_d = ST_STOP;
    end else if (start_det && ph_q != P_IGNORE) begin
      ph_d = P_RECV; cnt_d = '0; isaddr_d = 1'b1; rd_d = 1'b0;
      sdap_d = 1'b0; sclp_d = 1'b0;
    end else begin
      unique case (ph_q)
        P_RECV: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == LAST_BIT) begin
            if (ack_en && (!isaddr_q || hit)) begin
              sdap_d   = 1'b1;
              rx_d     = sh_q;
              isaddr_d = 1'b0;
              if (isaddr_q && rd_bit) begin
                rd_d = 1'b1;
                ph_d = P_ACK;
              end else begin
                ph_d   = P_HOLD;
                sclp_d = 1'b1;
                hold_d = 1'b1;
                st_d   = !isaddr_q ? ST_RX_ACK : (gcall ? ST_GCALL : ST_ADDR_WR);
              end
            end else begin
              ph_d = P_IGNORE;
            end
          end
        end
        P_HOLD: begin
          if (hold_clr) begin
            sclp_d = 1'b0;
            ph_d   = P_ACK;
          end
        end
        P_ACK: begin
          if (scl_fall) begin
            sdap_d = 1'b0;
            cnt_d  = '0;
            if (rd_q) begin
              ph_d = P_TXWAIT; sclp_d = 1'b1; hold_d = 1'b1; st_d = ST_ADDR_RD;
            end else begin
              ph_d = P_RECV;
            end
          end
        end
        P_TXWAIT: begin
          if (hold_clr) begin
            sh_d   = tx_byte;
            sdap_d = ~tx_byte[BYTE_W-1];
            sclp_d = 1'b0;
            cnt_d  = '0;
            ph_d   = P_SEND;
          end
        end
        P_SEND: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              sdap_d = 1'b0;
              ph_d   = P_MACK;
            end else begin
              sh_d   = {sh_q[BYTE_W-2:0], 1'b0};
              sdap_d = ~sh_q[BYTE_W-2];
            end
          end
        end
        P_MACK: begin
          if (scl_rise) begin
            sh_d[0] = sda_s;
          end else if (scl_fall) begin
            cnt_d  = '0;
            hold_d = 1'b1;
            if (!sh_q[0]) begin
              ph_d = P_TXWAIT; sclp_d = 1'b1; st_d = ST_TX_ACK;
            end else begin
              ph_d = P_IGNORE; st_d = ST_TX_NACK;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ph_q <= P_IDLE; cnt_q <= '0; sh_q <= '0; rx_q <= '0;
      isaddr_q <= 1'b0; rd_q <= 1'b0; hold_q <= 1'b0;
      sdap_q <= 1'b0; sclp_q <= 1'b0; st_q <= ST_IDLE;
    end else begin
      ph_q <= ph_d; cnt_q <= cnt_d; sh_q <= sh_d; rx_q <= rx_d;
      isaddr_q <= isaddr_d; rd_q <= rd_d; hold_q <= hold_d;
      sdap_q <= sdap_d; sclp_q <= sclp_d; st_q <= st_d;
    end
  end

  assign scl_pull  = sclp_q;
  assign sda_pull  = sdap_q;
  assign rx_byte   = rx_q;
  assign hold_flag = hold_q;
  assign status    = st_q;

  // R7: a stretch always has a pending handoff behind it
  a_r7_stretch_has_flag: assert property (@(posedge clk) disable iff (!rst_i)
    scl_pull |-> hold_flag);
  // R2: the target only starts pulling SDA while SCL is low
  a_r2_sda_set_scl_low: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(sda_pull) |-> !scl_s);
  // R4: with acknowledge disabled, SDA is pulled only to send data bits
  a_r4_no_ack_disabled: assert property (@(posedge clk) disable iff (!rst_i)
    ($rose(sda_pull) && !$past(ack_en)) |-> (ph_q == P_SEND));
  // R6: an ignoring target leaves both lines alone
  a_r6_ignore_silent: assert property (@(posedge clk) disable iff (!rst_i)
    (ph_q == P_IGNORE) |-> (!sda_pull && !scl_pull));
  // R10: STOP is reported on the next cycle
  a_r10_stop_status: assert property (@(posedge clk) disable iff (!rst_i)
    stop_det |=> (status == ST_STOP));
  // R11: a START outside the ignore phase restarts the bit count
  a_r11_restart: assert property (@(posedge clk) disable iff (!rst_i)
    (start_det && ph_q != P_IGNORE) |=> (ph_q == P_RECV && cnt_q == '0));

endmodule

// File: tb/sim_i2cs_core.sv
module sim_i2cs_core;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_pull, sda_pull, hold_flag;
  logic [6:0] own_addr = 7'h34;
  logic ack_en = 1'b1, gcall_en = 1'b0, hold_clr = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic [7:0] rx_byte;
  logic [2:0] status;
  wire scl_line = m_scl & ~scl_pull;
  wire sda_line = m_sda & ~sda_pull;

  int tests = 0, fails = 0, cyc = 0;
  logic mon_on = 1'b0, saw_pull = 1'b0, prev_scl = 1'b1, prev_sda = 1'b0;
  logic g_hold, g_sp;
  logic [2:0] g_stat;
  logic [7:0] g_rx;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cs_core u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .own_addr(own_addr),
    .ack_en(ack_en), .gcall_en(gcall_en), .tx_byte(tx_byte),
    .rx_byte(rx_byte), .hold_flag(hold_flag), .hold_clr(hold_clr),
    .status(status)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-clock monitor: R2 SDA stable while SCL high; R6 pull observation
  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (scl_line && prev_scl && (sda_pull != prev_sda)) begin
        fails++;
        $display("FAIL R2: sda_pull moved to %0b while SCL high, expected %0b", sda_pull, prev_sda);
      end
      if (sda_pull || scl_pull) saw_pull = 1'b1;
    end
    prev_scl = scl_line;
    prev_sda = sda_pull;
    if (cyc > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: cycles %0d expected below %0d", cyc, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic wait_high();
    while (!scl_line) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk) hold_clr = 1'b1;
    @(negedge clk) hold_clr = 1'b0;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_q();
    m_scl = 1'b1; wait_high(); wait_q();
    m_sda = 1'b0; wait_q();
    m_scl = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_q();
    m_scl = 1'b1; wait_high(); wait_q();
    m_sda = 1'b1; wait_q();
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wait_q();
    m_scl = 1'b1; wait_high(); wait_q();
    m_scl = 1'b0; wait_q();
  endtask

  // writes a byte; the host service happens before the ninth rising edge
  task automatic write_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; wait_q();
    g_hold = hold_flag; g_stat = status; g_rx = rx_byte; g_sp = scl_pull;
    if (hold_flag) pulse_clr();
    m_scl = 1'b1; wait_high(); wait_q();
    ack = sda_line;
    m_scl = 1'b0; wait_q();
  endtask

  task automatic service(input logic [7:0] tx);
    wait_q();
    g_hold = hold_flag; g_stat = status; g_sp = scl_pull;
    tx_byte = tx;
    if (hold_flag) pulse_clr();
  endtask

  task automatic read_byte(input logic nack, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; wait_q();
      m_scl = 1'b1; wait_high(); wait_q();
      got[i] = sda_line;
      m_scl = 1'b0; wait_q();
    end
    send_bit(nack);
    m_sda = 1'b1;
  endtask

  initial begin
    logic ack;
    logic [7:0] rd;
    repeat (5) @(negedge clk);
    // R12: reset state
    check("R12 status", status, 0);
    check("R12 scl_pull", scl_pull, 0);
    check("R12 sda_pull", sda_pull, 0);
    check("R12 hold_flag", hold_flag, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    mon_on = 1'b1;

    // R1 R2 R5 R7: write to own address 0x34 (byte 0x68), two data bytes
    bus_start();
    write_byte(8'h68, ack);
    check("R2 address ACK", ack, 0);
    check("R7 hold on write address", g_hold, 1);
    check("R7 SCL stretched", g_sp, 1);
    check("R5 status write address", g_stat, 1);
    check("R1 address byte MSB first", g_rx, 8'h68);
    write_byte(8'hA5, ack);
    check("R5 data ACK", ack, 0);
    check("R5 status data", g_stat, 4);
    check("R5 rx_byte A5", g_rx, 8'hA5);
    write_byte(8'h3C, ack);
    check("R5 rx_byte 3C", g_rx, 8'h3C);
    check("R7 hold on data", g_hold, 1);
    bus_stop();
    wait_q();
    check("R10 status stop", status, 7);
    check("R10 sda released", sda_pull, 0);

    // R6: other address; bytes and a START ignored until STOP
    saw_pull = 1'b0;
    bus_start();
    write_byte(8'h6A, ack);
    check("R6 no ACK other address", ack, 1);
    write_byte(8'h68, ack);
    check("R6 data ignored", ack, 1);
    check("R6 no handoff", g_hold, 0);
    bus_start();
    write_byte(8'h68, ack);
    check("R6 START ignored before STOP", ack, 1);
    check("R6 no line pulled", saw_pull, 0);
    bus_stop();

    // R3: general call
    bus_start();
    write_byte(8'h00, ack);
    check("R3 general call refused", ack, 1);
    bus_stop();
    gcall_en = 1'b1;
    bus_start();
    write_byte(8'h00, ack);
    check("R3 general call ACK", ack, 0);
    check("R3 status general call", g_stat, 3);
    bus_stop();
    gcall_en = 1'b0;

    // R4: acknowledge disabled
    ack_en = 1'b0;
    saw_pull = 1'b0;
    bus_start();
    write_byte(8'h68, ack);
    check("R4 no ACK when disabled", ack, 1);
    check("R4 no handoff when disabled", g_hold, 0);
    check("R4 no pull when disabled", saw_pull, 0);
    bus_stop();
    ack_en = 1'b1;

    // R11 R8 R9: write, repeated START, read two bytes
    bus_start();
    write_byte(8'h68, ack);
    write_byte(8'h10, ack);
    check("R5 register byte", g_rx, 8'h10);
    bus_start();
    write_byte(8'h69, ack);
    check("R11 read address ACK after repeated START", ack, 0);
    check("R8 no stretch before ninth clock", g_hold, 0);
    service(8'hC3);
    check("R8 hold after read address", g_hold, 1);
    check("R8 status read address", g_stat, 2);
    check("R8 SCL stretched", g_sp, 1);
    read_byte(1'b0, rd);
    check("R8 sent byte C3", rd, 8'hC3);
    service(8'h5A);
    check("R9 status sent ACKed", g_stat, 5);
    check("R9 stretch after ACK", g_sp, 1);
    read_byte(1'b1, rd);
    check("R8 sent byte 5A", rd, 8'h5A);
    wait_q();
    check("R9 status sent NACKed", status, 6);
    check("R9 hold after NACK", hold_flag, 1);
    check("R9 no stretch after NACK", scl_pull, 0);
    check("R9 SDA released after NACK", sda_pull, 0);
    pulse_clr();
    bus_stop();
    wait_q();
    check("R10 stop after read", status, 7);
    check("R10 hold cleared", hold_flag, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule